// File: doc/BRIEF.md
# Watchdog Sleep-Mode Timebase Switcher

This block sits beside a windowed watchdog and decides which oscillator drives the reset generator. The watchdog raises a one-cycle strobe each time a full reset pulse period ends. One period is the closed window, the open window and the reset pulse. If the host processor gives no service activity for a set number of these periods in a row, the host is taken to be asleep. The block then selects a slow, low-power internal timebase. With that timebase the reset generator gives a short pulse about once a second, and the pulse lasts 1/320 of that slow period.

The normal programmable timebase returns when the service input shows activity again, meaning either a rising or a falling edge. It also returns when power-good drops and comes back. Service edges pass through a two-flop synchronizer before edge detection. The select changes only at a period boundary, so a reset pulse is never cut short. The only exception is a power-good loss, which clears the select at once. Both oscillators are outside the block and arrive as tick inputs. The block forwards the selected one.

Top module: `wd_sleep_switch`

## Requirements
- R1: After the synchronous active-low reset, `slow_sel` is 0 (0 = programmable timebase, 1 = slow timebase).
- R2: `slow_sel` rises in the cycle after the clock edge that samples the third `period_done` strobe with no service edge since the last clear. It is 0 after only two such strobes.
- R3: A service edge of either polarity while in normal mode restarts the count, so three further strobes are needed. The edge takes effect for any strobe sampled two or more clock edges after the edge that first samples the new level of `svc_in`.
- R4: A service edge of either polarity while `slow_sel` is 1 does not clear `slow_sel` at once. `slow_sel` falls in the cycle after the next `period_done` strobe.
- R5: While `pwr_good` is 0, `slow_sel` is 0 from the next cycle and the count is cleared. After recovery, three strobes are needed again.
- R6: `slow_sel` never rises except in the cycle after a `period_done` strobe.
- R7: Extra strobes while in slow mode keep `slow_sel` at 1, because the count saturates.
- R8: `sel_tick` equals `slow_tick` when `slow_sel` is 1, and equals `fast_tick` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_in | input | 1 | Asynchronous watchdog service input from the host |
| period_done | input | 1 | One-cycle strobe at the end of each reset pulse period |
| pwr_good | input | 1 | Supply-good indication; low clears the block state |
| fast_tick | input | 1 | Tick from the programmable oscillator |
| slow_tick | input | 1 | Tick from the slow internal oscillator |
| slow_sel | output | 1 | Timebase select, 1 = slow internal timebase |
| sel_tick | output | 1 | Tick of the selected timebase |

## Verification
Directed sequences try the following cases:
- Two and then three quiet periods, to separate an off-by-one entry point from the correct one.
- A rising and then a falling service edge during slow mode. These show that both polarities wake the block and that the wake waits for the period boundary.
- A power-good dip in the middle of counting, which shows that the count is cleared and not just paused.

Random mixes of strobes, service toggles, power dips and tick values then compare the select and the forwarded tick against an event-level model of the requirements. These mixes reach saturation and repeated entry and exit.

// File: rtl/wdsl_pkg.sv
// Shared types for the sleep-mode timebase switcher.
package wdsl_pkg;

    // Timebase choice handed to the reset generator.
    typedef enum logic {
        TB_PROG = 1'b0,
        TB_SLOW = 1'b1
    } tb_sel_e;

endpackage

// File: rtl/wdsl_edge_sync.sv
// Two-flop synchronizer for the asynchronous service input, followed by a
// detector that pulses for one cycle on a change of either polarity.
// Assumes svc_in is held low during reset; a high level at reset release
// is reported as one edge.
module wdsl_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Sample the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
        end
    end

    // Keep the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Any level change is an edge.
    always_comb edge_pulse = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/wdsl_quiet_cnt.sv
// Saturating count of reset pulse periods that passed with no service edge.
// Cleared by a service edge or by power-good loss; the clear wins over a
// strobe in the same cycle.
module wdsl_quiet_cnt #(
    parameter int LIMIT = 3,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          count_en,
    output logic [CW-1:0] count,
    output logic          at_last
);
    localparam logic [CW-1:0] MAXV = CW'(LIMIT);
    localparam logic [CW-1:0] LASTV = CW'(LIMIT - 1);

    // Advance, clear or hold the quiet-period count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (count_en && count != MAXV) begin
            count <= count + 1'b1;
        end
    end

    // Flag that the next strobe completes the required number.
    always_comb at_last = (count == LASTV);

endmodule

// File: rtl/wdsl_mode_reg.sv
// Registered timebase select. Entry and wake both take effect only on a
// period boundary; a wake request seen mid-period is held as pending.
// Power-good loss clears the select immediately.
module wdsl_mode_reg
    import wdsl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pwr_good,
    input  logic    boundary,
    input  logic    enter_ok,
    input  logic    wake_evt,
    output tb_sel_e mode,
    output logic    wake_pend
);
    // Hold the current timebase choice.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            mode <= TB_PROG;
        end else if (boundary) begin
            if (mode == TB_SLOW && (wake_pend || wake_evt)) mode <= TB_PROG;
            else if (mode == TB_PROG && enter_ok)           mode <= TB_SLOW;
        end
    end

    // Remember a service edge seen in slow mode until the next boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            wake_pend <= 1'b0;
        end else if (boundary) begin
            wake_pend <= 1'b0;
        end else if (mode == TB_SLOW && wake_evt) begin
            wake_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/wd_sleep_switch.sv
// Top of the sleep-mode timebase switcher: counts unserviced watchdog reset
// periods and selects the slow internal timebase after SLEEP_PERIODS of them.
// Assumes period_done is a single-cycle strobe in the clk domain.
module wd_sleep_switch
    import wdsl_pkg::*;
#(
    parameter int SLEEP_PERIODS = 3,
    parameter int SYNC_STAGES   = 2,
    localparam int CW           = $clog2(SLEEP_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_in,
    input  logic period_done,
    input  logic pwr_good,
    input  logic fast_tick,
    input  logic slow_tick,
    output logic slow_sel,
    output logic sel_tick
);
    logic          svc_edge;
    logic [CW-1:0] quiet_cnt;
    logic          cnt_last;
    logic          wake_pend;
    tb_sel_e       mode;

    wdsl_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (svc_in),
        .edge_pulse(svc_edge)
    );

    wdsl_quiet_cnt #(.LIMIT(SLEEP_PERIODS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (svc_edge || !pwr_good),
        .count_en(period_done && !wake_pend),
        .count   (quiet_cnt),
        .at_last (cnt_last)
    );

    wdsl_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .boundary (period_done),
        .enter_ok (cnt_last && !svc_edge),
        .wake_evt (svc_edge),
        .mode     (mode),
        .wake_pend(wake_pend)
    );

    // Drive the select and forward the chosen oscillator tick.
    always_comb begin
        slow_sel = (mode == TB_SLOW);
        sel_tick = slow_sel ? slow_tick : fast_tick;
    end

endmodule

// File: rtl/wdsl_checker.sv
// Property checker for the sleep-mode timebase switcher, bound to the top.
// Keeps its own saturating count of edge-free strobes.
module wdsl_checker #(
    parameter int N = 3
) (
    input logic clk,
    input logic rst_n,
    input logic period_done,
    input logic pwr_good,
    input logic svc_edge,
    input logic slow_sel
);
    localparam int CCW = $clog2(N + 1);
    logic [CCW-1:0] chk_cnt;

    // Independent count of quiet strobes since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good || svc_edge) chk_cnt <= '0;
        else if (period_done && chk_cnt != CCW'(N)) chk_cnt <= chk_cnt + 1'b1;
    end

    // R1: reset leaves the programmable timebase selected.
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !slow_sel);

    // R2: entry only after the required number of quiet strobes.
    p_enter_after_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_sel) |-> chk_cnt == CCW'(N));

    // R6: entry only on a period boundary.
    p_rise_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_sel) |-> $past(period_done));

    // R4: exit only on a boundary or on power loss.
    p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_sel) |-> ($past(period_done) || !$past(pwr_good)));

    // R5: power-good loss forces the programmable timebase.
    p_pg_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !slow_sel);

endmodule

bind wd_sleep_switch wdsl_checker #(.N(SLEEP_PERIODS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_done(period_done),
    .pwr_good   (pwr_good),
    .svc_edge   (svc_edge),
    .slow_sel   (slow_sel)
);

// File: tb/wd_sleep_switch_tb.sv
module wd_sleep_switch_tb;
    logic clk = 1'b0;
    logic rst_n, svc_in, period_done, pwr_good, fast_tick, slow_tick;
    logic slow_sel, sel_tick;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Event-level reference state.
    int   m_cnt;
    bit   m_slow;
    bit   m_pend;

    always #2 clk = ~clk;

    wd_sleep_switch u_dut (
        .clk(clk), .rst_n(rst_n), .svc_in(svc_in), .period_done(period_done),
        .pwr_good(pwr_good), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .slow_sel(slow_sel), .sel_tick(sel_tick)
    );

    function automatic bit exp_tick(bit s, bit f, bit sl);
        return s ? sl : f;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; svc_in = 1'b0; period_done = 1'b0; pwr_good = 1'b1;
        fast_tick = 1'b0; slow_tick = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        m_cnt = 0; m_slow = 0; m_pend = 0;
    endtask

    // One period-complete strobe; select checked one cycle after sampling.
    task automatic strobe(string req);
        @(negedge clk) period_done = 1'b1;
        @(negedge clk) period_done = 1'b0;
        if (m_slow && m_pend) begin
            m_slow = 0; m_pend = 0; m_cnt = 0;
        end else if (!m_slow && !m_pend) begin
            if (m_cnt < 3) m_cnt++;
            if (m_cnt == 3) m_slow = 1;
        end
        check(req, slow_sel, m_slow);
        repeat (3) @(negedge clk);
    endtask

    task automatic toggle(string req);
        @(negedge clk) svc_in = ~svc_in;
        if (m_slow) m_pend = 1;
        m_cnt = 0;
        repeat (5) @(negedge clk);
        check(req, slow_sel, m_slow);
    endtask

    task automatic pg_dip(string req);
        @(negedge clk) pwr_good = 1'b0;
        @(negedge clk);
        m_slow = 0; m_pend = 0; m_cnt = 0;
        check(req, slow_sel, 1'b0);
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic tick_chk(bit f, bit s);
        @(negedge clk) begin fast_tick = f; slow_tick = s; end
        #1 check("R8", sel_tick, exp_tick(m_slow, f, s));
    endtask

    initial begin
        void'($urandom(32'd1455));
        do_reset();
        check("R1", slow_sel, 1'b0);
        tick_chk(1'b1, 1'b0);                // R8 normal source
        strobe("R2"); strobe("R2");
        check("R2 two periods not enough", slow_sel, 1'b0);
        strobe("R2");                        // third: enters slow
        check("R2 entered", slow_sel, 1'b1);
        tick_chk(1'b0, 1'b1);                // R8 slow source
        strobe("R7"); strobe("R7");          // saturation keeps slow
        toggle("R4 rising edge waits");      // stays slow until boundary
        strobe("R4 rising wake");
        check("R4 left slow", slow_sel, 1'b0);
        strobe("R3"); strobe("R3");
        toggle("R3 falling edge in normal");
        strobe("R3"); strobe("R3");
        check("R3 count restarted", slow_sel, 1'b0);
        strobe("R3");
        check("R3 entered after restart", slow_sel, 1'b1);
        toggle("R4 falling edge waits");
        strobe("R4 falling wake");
        check("R4 left slow", slow_sel, 1'b0);
        strobe("R5"); strobe("R5");
        pg_dip("R5 dip");
        strobe("R5"); strobe("R5");
        check("R5 count cleared", slow_sel, 1'b0);
        strobe("R5"); strobe("R5"); strobe("R5");
        pg_dip("R5 immediate exit");
        // Random mix against the reference.
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(99);
            if (r < 60)      strobe("R2/R6 random");
            else if (r < 85) toggle("R3/R4 random");
            else if (r < 90) pg_dip("R5 random");
            else             tick_chk(1'($urandom_range(1)), 1'($urandom_range(1)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule